// File: doc/BRIEF.md
# Routed Input Timestamp Capture

This block keeps a free-running timestamp and records the moment at which events occur on a bank of 32 asynchronous digital inputs. The block is clocked at the timestamp rate, nominally 20 MHz, and the counter advances by one on every clock. The counter wraps around without stopping, and software can zero it.

The block has four capture slots, and all of them share the one counter. Each slot has its own 5-bit selector, so any slot can watch any input, and two slots can watch the same input. A rising edge on the selected input, after it has passed through a two-flop synchronizer, loads the slot with the current count and sets the slot's valid flag. A slot that already holds an unread value keeps that value and raises an overflow flag.

One input is wired as the trigger. Each accepted trigger does three things: it increments a trigger counter, latches a trigger timestamp, and raises a busy output. Busy stays high until software clears it, and triggers that arrive while busy is high are dropped. All state is reached through a word-wide register port. Reads return data in the same cycle, and reading a capture slot releases that slot.

Top module: `ts_capture_unit`

## Requirements
- R1: The counter (address 0x0) advances by one on every clock after reset and wraps from its maximum value to 0 without stopping.
- R2: A write to address 0x0, whatever the data, makes the counter read 0 in the cycle after the write. The counter then continues to advance from 0.
- R3: Each input passes through two synchronizing flops. An input that is first sampled high at clock edge E0, after being sampled low at the edge before, gives a rising edge. The selected slot then loads the counter value that is visible between edge E1 and edge E2. Slot k is read at address 0x8+k.
- R4: The selector for slot k is a 5-bit input index held in bits [8k+4:8k] of address 0x1. It resets to 0 and reads back as written. Any of the 32 inputs may go to any slot.
- R5: Status at address 0x2 holds valid of slot k in bit k and overflow of slot k in bit 8+k. A capture sets the valid bit. A read of slot k clears both the valid and overflow bits of slot k, unless a new capture lands in the same cycle.
- R6: A rising edge that reaches a slot whose valid bit is set, and that is not accompanied by a read of that slot, leaves the stored value unchanged and sets the slot's overflow bit.
- R7: A falling edge or a steady high level on the selected input captures nothing.
- R8: A rising edge on input 1 that is accepted increments the trigger count (address 0x3) and latches the counter into the trigger timestamp (address 0x4).
- R9: busy_o goes high in the same cycle as the accepted trigger edge is detected. Bit 16 of status mirrors busy. Busy holds until a write to address 0x2 with bit 16 set, and it drops in the cycle after that write.
- R10: Trigger edges that arrive while busy is held change neither the trigger count nor the trigger timestamp.
- R11: After reset the counter, selectors, status, trigger count, trigger timestamp and busy_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timestamp clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_i | input | 32 | Asynchronous event inputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (side effects on capture slots) |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, same cycle |
| busy_o | output | 1 | Trigger busy |

## Verification
A corrupted synchronizer stage or a wrong selector would show up as a capture that lands a cycle early or late. It could also show as a valid bit that comes from the wrong input, and the stored counter value reveals the error as soon as the slot is read. A valid or overflow flag that is stuck would show in the status word on the next clock. It would also show as a slot value that changes while it should hold. A bad busy latch would show at busy_o within one cycle of the trigger edge or of the clear write, and it would also show as trigger counts that advance while busy is held.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int ADDR_W     = 4;
  localparam int SEL_STRIDE = 8;
  localparam int STAT_OVF   = 8;
  localparam int STAT_BUSY  = 16;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'h0;
  localparam logic [ADDR_W-1:0] A_SEL  = 4'h1;
  localparam logic [ADDR_W-1:0] A_STAT = 4'h2;
  localparam logic [ADDR_W-1:0] A_TCNT = 4'h3;
  localparam logic [ADDR_W-1:0] A_TTS  = 4'h4;
  localparam logic [ADDR_W-1:0] A_CAP0 = 4'h8;
endpackage

// File: rtl/ts_sync_edge.sv
module ts_sync_edge #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;

  for (genvar b = 0; b < W; b++) begin : g_chk
    assert_single_pulse_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[b] |=> !rise_o[b]);
  end
endmodule

// File: rtl/ts_capture_slot.sv
module ts_capture_slot #(
  parameter int TS_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            edge_i,
  input  logic            rd_i,
  input  logic [TS_W-1:0] ts_i,
  output logic [TS_W-1:0] ts_o,
  output logic            valid_o,
  output logic            ovf_o
);
  logic [TS_W-1:0] ts_q;
  logic            valid_q, ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q    <= '0;
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (edge_i && (!valid_q || rd_i)) begin
      ts_q    <= ts_i;
      valid_q <= 1'b1;
      ovf_q   <= 1'b0;
    end else if (edge_i) begin
      ovf_q   <= 1'b1;
    end else if (rd_i) begin
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end
  end

  assign ts_o    = ts_q;
  assign valid_o = valid_q;
  assign ovf_o   = ovf_q;

  assert_hold_while_valid_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !rd_i |=> $stable(ts_q));
  assert_overflow_flag_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i && valid_q && !rd_i |=> ovf_q);
  assert_valid_on_edge_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> valid_q);
  assert_read_releases_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !edge_i |=> !valid_q && !ovf_q);
endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit
  import ts_pkg::*;
#(
  parameter int TS_W     = 32,
  parameter int N_IN     = 32,
  parameter int N_CAP    = 4,
  parameter int TRIG_IDX = 1,
  parameter int TCNT_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IN-1:0]   in_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              busy_o
);
  localparam int SEL_W = $clog2(N_IN);

  logic [N_IN-1:0]  rise;
  logic [TS_W-1:0]  cnt_q, tts_q;
  logic [TCNT_W-1:0] tcnt_q;
  logic             busy_q, trig_rise, trig_acc, busy_clr, cnt_clr;
  logic [SEL_W-1:0] sel_q [N_CAP];
  logic [TS_W-1:0]  cap_ts [N_CAP];
  logic [N_CAP-1:0] slot_edge, slot_rd, valid, ovf;

  ts_sync_edge #(.W(N_IN)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (in_i),
    .rise_o(rise)
  );

  assign cnt_clr   = reg_we_i && (reg_addr_i == A_CNT);
  assign busy_clr  = reg_we_i && (reg_addr_i == A_STAT) && reg_wdata_i[STAT_BUSY];
  assign trig_rise = rise[TRIG_IDX];
  assign trig_acc  = trig_rise && !busy_q;
  assign busy_o    = busy_q || trig_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_clr) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tcnt_q <= '0;
      tts_q  <= '0;
    end else if (trig_acc) begin
      busy_q <= 1'b1;
      tcnt_q <= tcnt_q + 1'b1;
      tts_q  <= cnt_q;
    end else if (busy_clr) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_CAP; k++) sel_q[k] <= '0;
    end else if (reg_we_i && reg_addr_i == A_SEL) begin
      for (int k = 0; k < N_CAP; k++) sel_q[k] <= reg_wdata_i[k*SEL_STRIDE +: SEL_W];
    end
  end

  for (genvar k = 0; k < N_CAP; k++) begin : g_slot
    assign slot_edge[k] = rise[sel_q[k]];
    assign slot_rd[k]   = reg_re_i && (reg_addr_i == A_CAP0 + ADDR_W'(k));
    ts_capture_slot #(.TS_W(TS_W)) i_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .edge_i (slot_edge[k]),
      .rd_i   (slot_rd[k]),
      .ts_i   (cnt_q),
      .ts_o   (cap_ts[k]),
      .valid_o(valid[k]),
      .ovf_o  (ovf[k])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CNT:  reg_rdata_o = 32'(cnt_q);
      A_SEL:  for (int k = 0; k < N_CAP; k++) reg_rdata_o[k*SEL_STRIDE +: SEL_W] = sel_q[k];
      A_STAT: begin
        reg_rdata_o[N_CAP-1:0]           = valid;
        reg_rdata_o[STAT_OVF +: N_CAP]   = ovf;
        reg_rdata_o[STAT_BUSY]           = busy_q;
      end
      A_TCNT: reg_rdata_o = 32'(tcnt_q);
      A_TTS:  reg_rdata_o = 32'(tts_q);
      default: begin
        for (int k = 0; k < N_CAP; k++)
          if (reg_addr_i == A_CAP0 + ADDR_W'(k)) reg_rdata_o = 32'(cap_ts[k]);
      end
    endcase
  end

  assert_count_step_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_clr |=> cnt_q == TS_W'($past(cnt_q) + 1'b1));
  assert_count_zero_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr |=> cnt_q == '0);
  assert_busy_hold_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !busy_clr |=> busy_q);
  assert_no_count_busy_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(tcnt_q) && $stable(tts_q));
endmodule

// File: tb/test_ts_capture_unit.sv
module test_ts_capture_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ins = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata, rdata_n;
  logic        busy, busy_n;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  ts_capture_unit i_ts_capture_unit (
    .clk_i(clk), .rst_ni(rst_n), .in_i(ins), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wd), .reg_rdata_o(rdata), .busy_o(busy));

  ts_capture_unit #(.TS_W(8)) i_ts_capture_unit_narrow (
    .clk_i(clk), .rst_ni(rst_n), .in_i(ins), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wd), .reg_rdata_o(rdata_n), .busy_o(busy_n));

  // reference model state
  logic [31:0] m_cnt, m_tcnt, m_tts;
  logic [4:0]  m_sel [4];
  logic [31:0] m_cap [4];
  logic [3:0]  m_val, m_ovf;
  logic        m_busy;
  logic [31:0] samp [$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_tcnt = 0; m_tts = 0; m_busy = 0; m_val = 0; m_ovf = 0;
      for (int k = 0; k < 4; k++) begin m_sel[k] = 0; m_cap[k] = 0; end
      samp = '{32'h0, 32'h0, 32'h0};
    end else begin
      logic [31:0] r;
      r = samp[1] & ~samp[2];
      for (int k = 0; k < 4; k++) begin
        bit e, rk;
        e  = r[m_sel[k]];
        rk = re && (addr == 4'(8 + k));
        if (e && (!m_val[k] || rk)) begin m_cap[k] = m_cnt; m_val[k] = 1; m_ovf[k] = 0; end
        else if (e) m_ovf[k] = 1;
        else if (rk) begin m_val[k] = 0; m_ovf[k] = 0; end
      end
      if (r[1] && !m_busy) begin m_tcnt++; m_tts = m_cnt; m_busy = 1; end
      else if (we && addr == 4'h2 && wd[16]) m_busy = 0;
      if (we && addr == 4'h1)
        for (int k = 0; k < 4; k++) m_sel[k] = wd[k*8 +: 5];
      m_cnt = (we && addr == 4'h0) ? 32'h0 : m_cnt + 1;
      samp.push_front(ins);
      void'(samp.pop_back());
    end
  end

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    case (a)
      4'h0: return m_cnt;
      4'h1: return {3'b0, m_sel[3], 3'b0, m_sel[2], 3'b0, m_sel[1], 3'b0, m_sel[0]};
      4'h2: return {15'b0, m_busy, 4'b0, m_ovf, 4'b0, m_val};
      4'h3: return m_tcnt;
      4'h4: return m_tts;
      4'h8, 4'h9, 4'hA, 4'hB: return m_cap[a - 4'h8];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'h0: return "R1 counter";
      4'h1: return "R4 selectors";
      4'h2: return "R5 status";
      4'h3, 4'h4: return "R8 trigger regs";
      default: return "R3 capture slot";
    endcase
  endfunction

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(tag_of(addr), rdata, exp_rd(addr));
      check("R9 busy_o", 32'(busy), 32'(m_busy | (samp[1][1] & ~samp[2][1])));
      if (addr == 4'h0) check("R1 narrow wrap", rdata_n, {24'h0, m_cnt[7:0]});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #2; we = 1; addr = a; wd = d;
    @(posedge clk); #2; we = 0;
  endtask
  task automatic peek(input logic [3:0] a, output logic [31:0] v);
    @(posedge clk); #2; addr = a;
    @(negedge clk); v = rdata;
  endtask
  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(posedge clk); #2; addr = a; re = 1;
    @(negedge clk); v = rdata;
    @(posedge clk); #2; re = 0;
  endtask
  task automatic pulse(input int b, input int len);
    @(posedge clk); #2; ins[b] = 1;
    repeat (len) @(posedge clk);
    #2; ins[b] = 0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #4000000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v, v1;
    // R11: reset state
    repeat (3) @(negedge clk);
    check("R11 counter in reset", rdata, 32'h0);
    check("R11 busy in reset", 32'(busy), 32'h0);
    addr = 4'h2; #1; check("R11 status in reset", rdata, 32'h0);
    addr = 4'h1; #1; check("R11 selectors in reset", rdata, 32'h0);
    addr = 4'h3; #1; check("R11 trigger count in reset", rdata, 32'h0);
    @(posedge clk); #2; rst_n = 1; addr = 4'h0;
    cyc(4);

    // R4: selectors
    wr(4'h1, {3'b0, 5'd1, 3'b0, 5'd31, 3'b0, 5'd20, 3'b0, 5'd5});
    peek(4'h1, v);
    check("R4 selector readback", v, 32'h011F1405);

    // R3 + R6: capture then ignored second edge
    pulse(5, 3); cyc(6);
    peek(4'h2, v);
    check("R5 valid after capture", v & 32'h101, 32'h001);
    peek(4'h8, v1);
    pulse(5, 3); cyc(6);
    peek(4'h2, v);
    check("R6 overflow set", v & 32'h101, 32'h101);
    rd(4'h8, v);
    check("R6 value kept", v, v1);
    peek(4'h2, v);
    check("R5 read releases slot", v & 32'h101, 32'h0);
    pulse(31, 2); cyc(6);
    peek(4'h2, v);
    check("R3 slot2 from input 31", v & 32'h4, 32'h4);

    // R7: level and falling edge
    @(posedge clk); #2; ins[20] = 1;
    cyc(6);
    rd(4'h9, v);
    cyc(4);
    peek(4'h2, v);
    check("R7 steady high no recapture", v & 32'h2, 32'h0);
    @(posedge clk); #2; ins[20] = 0;
    cyc(6);
    peek(4'h2, v);
    check("R7 falling edge ignored", v & 32'h2, 32'h0);

    // R8, R9, R10: trigger
    pulse(1, 2); cyc(5);
    check("R9 busy held", 32'(busy), 32'h1);
    peek(4'h3, v);
    check("R8 trigger count", v, 32'h1);
    peek(4'h4, v1);
    pulse(1, 2); cyc(5);
    peek(4'h3, v);
    check("R10 count frozen while busy", v, 32'h1);
    peek(4'h4, v);
    check("R10 timestamp frozen while busy", v, v1);
    wr(4'h2, 32'h0001_0000);
    @(negedge clk);
    check("R9 busy cleared", 32'(busy), 32'h0);
    pulse(1, 2); cyc(5);
    peek(4'h3, v);
    check("R8 second accepted trigger", v, 32'h2);

    // R2: counter clear
    wr(4'h0, 32'hDEAD_BEEF);
    @(negedge clk);
    check("R2 counter zero after write", rdata, 32'h0);
    @(negedge clk);
    check("R2 counter resumes", rdata, 32'h1);

    // R1: wrap on the narrow instance
    begin
      int guard = 0;
      while (rdata_n !== 32'hFF && guard < 400) begin @(negedge clk); guard++; end
      check("R1 narrow reaches max", rdata_n, 32'hFF);
      @(negedge clk);
      check("R1 narrow wraps to zero", rdata_n, 32'h0);
    end

    // mixed stimulus, compared every cycle by the model
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #2;
      ins = ins ^ ($urandom() & $urandom() & $urandom());
      we = 0; re = 0;
      case ($urandom_range(0, 15))
        0: begin we = 1; addr = 4'h1; wd = $urandom(); end
        1: begin we = 1; addr = 4'h2; wd = 32'h0001_0000; end
        2: if ($urandom_range(0, 7) == 0) begin we = 1; addr = 4'h0; wd = 0; end
        3, 4, 5: begin re = 1; addr = 4'(8 + $urandom_range(0, 3)); end
        default: addr = 4'($urandom_range(0, 11));
      endcase
    end
    @(posedge clk); #2; we = 0; re = 0;
    cyc(4);
    finish_run();
  end
endmodule